// File: doc/BRIEF.md
# Branch and Skip Resolution Unit

This unit resolves the outcome of one control-transfer instruction per cycle. From the current program counter, the 8-bit status register and the fields a decoder has already pulled from the instruction, it decides whether control leaves the sequential path. It returns that decision, the next program counter and the number of cycles the instruction occupies. It handles four request kinds: a plain instruction, a conditional branch on one status flag, an unconditional relative jump, and a skip whose condition an earlier stage has already evaluated.

A conditional branch always comes down to one question: does status bit `idx` equal polarity `pol`? The caller can supply that pair directly. It can instead give a 4-bit condition name, which a small decoder turns into the same pair. The signed comparisons test N XOR V, recomputed from the N and V bits. Relative offsets are sign-extended to the PC width, and all PC arithmetic wraps modulo 2^PC_W.

Results are registered and appear on the clock edge after the request. When no request is present, the result outputs keep their last values.

Top module: `brskip_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the outputs become zero after that edge: `out_valid`, `out_taken`, `out_next_pc` and `out_cycles`.
- R2: `out_valid` is high in the cycle after `req_valid` was high and low otherwise. In a cycle after no request, `out_taken`, `out_next_pc` and `out_cycles` keep their previous values.
- R3: Kind 2'b01 with `use_named`=0 is taken exactly when `status[flag_idx]` equals `flag_pol`, for every index except 4. Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7.
- R4: Flag index 4 evaluates `status[2] ^ status[3]`. The stored `status[4]` has no effect on the outcome.
- R5: With `use_named`=1, `named_cond` selects (index, polarity) as follows:
  - 0 = (1,1), 1 = (1,0), 2 = (0,1), 3 = (0,0)
  - 4 = (2,1), 5 = (2,0), 6 = (4,0), 7 = (4,1)
  - 8 = (5,1), 9 = (5,0), 10 = (6,1), 11 = (6,0)
  - 12 = (3,1), 13 = (3,0), 14 = (7,1), 15 = (7,0)
  
  Codes 3 (same-or-higher) and 2 (lower) are therefore the carry-clear and carry-set tests.
- R6: A taken conditional branch gives `cur_pc + sext(rel_ofs) + 1` and 2 cycles. A branch that is not taken gives `cur_pc + 1` and 1 cycle.
- R7: Kind 2'b10 is a relative jump. It is always taken, targets `cur_pc + sext(rel_ofs) + 1`, uses 2 cycles and ignores every condition input.
- R8: Kind 2'b11 is a skip. With `skip_hit`=0 the result is not taken, `cur_pc + 1` and 1 cycle. With `skip_hit`=1 the result is taken, `cur_pc + 2` and 2 cycles when `next_two_word`=0, or `cur_pc + 3` and 3 cycles when `next_two_word`=1.
- R9: Kind 2'b00 gives not taken, `cur_pc + 1` and 1 cycle.
- R10: Every PC result wraps modulo 2^PC_W, including negative offsets from PC 0 and increments past the top address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_kind | input | 2 | 00 plain, 01 conditional branch, 10 relative jump, 11 skip |
| use_named | input | 1 | 1: use `named_cond`; 0: use `flag_idx`/`flag_pol` |
| named_cond | input | 4 | Named condition code (R5) |
| flag_idx | input | 3 | Status bit index for a raw test |
| flag_pol | input | 1 | Value of the flag that makes the branch taken |
| status | input | 8 | Status register |
| rel_ofs | input | OFS_W | Signed relative offset |
| cur_pc | input | PC_W | Address of the current instruction |
| skip_hit | input | 1 | Skip condition already evaluated as true |
| next_two_word | input | 1 | Instruction after the skip is two words long |
| out_valid | output | 1 | Result registered this cycle |
| out_taken | output | 1 | Control leaves the sequential path |
| out_next_pc | output | PC_W | Next program counter |
| out_cycles | output | 2 | Cycles used by the instruction |

## Verification
Every raw index is driven against a status byte and its complement. This separates a wrong bit select from a wrong polarity. The signed index is also driven with stored bit 4 set against N XOR V, which shows whether the stored bit or the recomputed one is used. All sixteen named codes run against the same patterns, so a swapped alias shows up as a flipped outcome.

Offsets at both signed extremes, and PCs at 0 and at the top address, expose missing sign extension and broken wrap. All four skip combinations tell the 2-cycle and 3-cycle distances apart. A long random stream with idle gaps, checked against a behavioural model every cycle, covers the hold behaviour and the interactions between kinds.

// File: rtl/brc_pkg.sv
// Shared types for the branch/skip resolution unit.
// Assumes an 8-bit status register with C,Z,N,V,S,H,T,I at bits 0..7.
package brc_pkg;

    localparam int STATUS_W = 8;
    localparam int FIDX_W   = 3;
    localparam int CYC_W    = 2;

    // Status bit positions
    localparam int BIT_C = 0;
    localparam int BIT_Z = 1;
    localparam int BIT_N = 2;
    localparam int BIT_V = 3;
    localparam int BIT_S = 4;
    localparam int BIT_H = 5;
    localparam int BIT_T = 6;
    localparam int BIT_I = 7;

    // Request kinds
    typedef enum logic [1:0] {
        KIND_PLAIN = 2'b00,
        KIND_COND  = 2'b01,
        KIND_JUMP  = 2'b10,
        KIND_SKIP  = 2'b11
    } brc_kind_e;

    // Named conditions
    typedef enum logic [3:0] {
        NC_EQUAL     = 4'd0,
        NC_UNEQUAL   = 4'd1,
        NC_BELOW     = 4'd2,
        NC_AT_LEAST  = 4'd3,
        NC_NEGATIVE  = 4'd4,
        NC_POSITIVE  = 4'd5,
        NC_SGE       = 4'd6,
        NC_SLT       = 4'd7,
        NC_HALF_ON   = 4'd8,
        NC_HALF_OFF  = 4'd9,
        NC_TBIT_ON   = 4'd10,
        NC_TBIT_OFF  = 4'd11,
        NC_OVF_ON    = 4'd12,
        NC_OVF_OFF   = 4'd13,
        NC_IRQ_ON    = 4'd14,
        NC_IRQ_OFF   = 4'd15
    } brc_named_e;

    // Generic flag test: index and expected value
    typedef struct packed {
        logic [FIDX_W-1:0] idx;
        logic              pol;
    } brc_test_t;

    // Result bundle of the PC stage
    typedef struct packed {
        logic             taken;
        logic [CYC_W-1:0] cycles;
    } brc_flow_t;

endpackage

// File: rtl/brc_cond_map.sv
// Turns either a named condition or a raw (index, polarity) pair into the
// generic flag test. Purely combinational; assumes named codes from brc_pkg.
module brc_cond_map
    import brc_pkg::*;
(
    input  logic              use_named,
    input  logic [3:0]        named_cond,
    input  logic [FIDX_W-1:0] raw_idx,
    input  logic              raw_pol,
    output brc_test_t         test
);

    brc_test_t named_test;

    // Decode a named condition into its flag index and polarity
    always_comb begin
        unique case (brc_named_e'(named_cond))
            NC_EQUAL:    named_test = '{idx: 3'(BIT_Z), pol: 1'b1};
            NC_UNEQUAL:  named_test = '{idx: 3'(BIT_Z), pol: 1'b0};
            NC_BELOW:    named_test = '{idx: 3'(BIT_C), pol: 1'b1};
            NC_AT_LEAST: named_test = '{idx: 3'(BIT_C), pol: 1'b0};
            NC_NEGATIVE: named_test = '{idx: 3'(BIT_N), pol: 1'b1};
            NC_POSITIVE: named_test = '{idx: 3'(BIT_N), pol: 1'b0};
            NC_SGE:      named_test = '{idx: 3'(BIT_S), pol: 1'b0};
            NC_SLT:      named_test = '{idx: 3'(BIT_S), pol: 1'b1};
            NC_HALF_ON:  named_test = '{idx: 3'(BIT_H), pol: 1'b1};
            NC_HALF_OFF: named_test = '{idx: 3'(BIT_H), pol: 1'b0};
            NC_TBIT_ON:  named_test = '{idx: 3'(BIT_T), pol: 1'b1};
            NC_TBIT_OFF: named_test = '{idx: 3'(BIT_T), pol: 1'b0};
            NC_OVF_ON:   named_test = '{idx: 3'(BIT_V), pol: 1'b1};
            NC_OVF_OFF:  named_test = '{idx: 3'(BIT_V), pol: 1'b0};
            NC_IRQ_ON:   named_test = '{idx: 3'(BIT_I), pol: 1'b1};
            default:     named_test = '{idx: 3'(BIT_I), pol: 1'b0};
        endcase
    end

    // Choose between the named and the raw form
    always_comb begin
        test = use_named ? named_test : '{idx: raw_idx, pol: raw_pol};
    end

endmodule

// File: rtl/brc_flag_eval.sv
// Evaluates one generic flag test against the status register.
// The signed-test slot is rebuilt as N xor V rather than taken from the
// stored bit, so a stale stored value cannot mislead a signed compare.
module brc_flag_eval
    import brc_pkg::*;
#(
    parameter int FLAG_N = STATUS_W
) (
    input  logic [FLAG_N-1:0] status,
    input  brc_test_t         test,
    output logic              hit
);

    logic [FLAG_N-1:0] eff_flag;

    // One effective flag per status position
    for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
        if (g == BIT_S) begin : g_signed
            assign eff_flag[g] = status[BIT_N] ^ status[BIT_V];
        end else begin : g_plain
            assign eff_flag[g] = status[g];
        end
    end

    // Compare the selected flag with the requested polarity
    always_comb begin
        hit = (eff_flag[test.idx] == test.pol);
    end

endmodule

// File: rtl/brc_pc_step.sv
// Computes the taken decision, next PC and cycle count for one request.
// Combinational; the offset is sign-extended and all sums wrap at PC_W bits.
module brc_pc_step
    import brc_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int OFS_W = 7
) (
    input  brc_kind_e         kind,
    input  logic              cond_hit,
    input  logic              skip_hit,
    input  logic              next_two_word,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [OFS_W-1:0]  rel_ofs,
    output brc_flow_t         flow,
    output logic [PC_W-1:0]   next_pc
);

    localparam int EXT_W = PC_W - OFS_W;

    logic [PC_W-1:0] ofs_ext;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] rel_pc;
    logic [PC_W-1:0] skip_pc;

    // Sign-extend or truncate the offset to the PC width
    if (EXT_W > 0) begin : g_extend
        assign ofs_ext = {{EXT_W{rel_ofs[OFS_W-1]}}, rel_ofs};
    end else begin : g_trunc
        assign ofs_ext = rel_ofs[PC_W-1:0];
    end

    // Candidate addresses
    always_comb begin
        seq_pc  = cur_pc + PC_W'(1);
        rel_pc  = seq_pc + ofs_ext;
        skip_pc = cur_pc + (next_two_word ? PC_W'(3) : PC_W'(2));
    end

    // Select the outcome for the request kind
    always_comb begin
        flow    = '{taken: 1'b0, cycles: CYC_W'(1)};
        next_pc = seq_pc;
        unique case (kind)
            KIND_COND: begin
                if (cond_hit) begin
                    flow    = '{taken: 1'b1, cycles: CYC_W'(2)};
                    next_pc = rel_pc;
                end
            end
            KIND_JUMP: begin
                flow    = '{taken: 1'b1, cycles: CYC_W'(2)};
                next_pc = rel_pc;
            end
            KIND_SKIP: begin
                if (skip_hit) begin
                    flow    = '{taken: 1'b1,
                                cycles: next_two_word ? CYC_W'(3) : CYC_W'(2)};
                    next_pc = skip_pc;
                end
            end
            default: begin
                flow    = '{taken: 1'b0, cycles: CYC_W'(1)};
                next_pc = seq_pc;
            end
        endcase
    end

endmodule

// File: rtl/brskip_unit.sv
// Top of the branch/skip resolution unit. Maps the condition, evaluates it,
// forms the next PC and registers the result one cycle after the request.
// Assumes the skip condition arrives already evaluated on skip_hit.
module brskip_unit
    import brc_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int OFS_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_kind,
    input  logic                use_named,
    input  logic [3:0]          named_cond,
    input  logic [2:0]          flag_idx,
    input  logic                flag_pol,
    input  logic [7:0]          status,
    input  logic [OFS_W-1:0]    rel_ofs,
    input  logic [PC_W-1:0]     cur_pc,
    input  logic                skip_hit,
    input  logic                next_two_word,
    output logic                out_valid,
    output logic                out_taken,
    output logic [PC_W-1:0]     out_next_pc,
    output logic [1:0]          out_cycles
);

    brc_test_t       test;
    logic            cond_hit;
    brc_flow_t       flow;
    logic [PC_W-1:0] next_pc;

    brc_cond_map u_map (
        .use_named  (use_named),
        .named_cond (named_cond),
        .raw_idx    (flag_idx),
        .raw_pol    (flag_pol),
        .test       (test)
    );

    brc_flag_eval #(.FLAG_N(STATUS_W)) u_eval (
        .status (status),
        .test   (test),
        .hit    (cond_hit)
    );

    brc_pc_step #(.PC_W(PC_W), .OFS_W(OFS_W)) u_step (
        .kind          (brc_kind_e'(req_kind)),
        .cond_hit      (cond_hit),
        .skip_hit      (skip_hit),
        .next_two_word (next_two_word),
        .cur_pc        (cur_pc),
        .rel_ofs       (rel_ofs),
        .flow          (flow),
        .next_pc       (next_pc)
    );

    // Register the result; hold it when no request is present
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_taken   <= 1'b0;
            out_next_pc <= '0;
            out_cycles  <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_taken   <= flow.taken;
                out_next_pc <= next_pc;
                out_cycles  <= flow.cycles;
            end
        end
    end

endmodule

// File: rtl/brskip_unit_chk.sv
// Checker for brskip_unit, attached by bind. Observes ports only.
module brskip_unit_chk #(
    parameter int PC_W  = 16,
    parameter int OFS_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_kind,
    input logic             use_named,
    input logic [2:0]       flag_idx,
    input logic             flag_pol,
    input logic [7:0]       status,
    input logic [OFS_W-1:0] rel_ofs,
    input logic [PC_W-1:0]  cur_pc,
    input logic             next_two_word,
    input logic             out_valid,
    input logic             out_taken,
    input logic [PC_W-1:0]  out_next_pc,
    input logic [1:0]       out_cycles
);

    logic [PC_W-1:0] rel_target;
    assign rel_target = cur_pc + {{(PC_W-OFS_W){rel_ofs[OFS_W-1]}}, rel_ofs} + PC_W'(1);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_taken && out_next_pc == '0 && out_cycles == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && $stable(out_taken) && $stable(out_next_pc)
                        && $stable(out_cycles)));

    // R3
    raw_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b01 && !use_named && flag_idx != 3'd4)
        |=> (out_taken == ($past(status[flag_idx]) == $past(flag_pol))));

    // R6
    branch_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b01) |=> (out_cycles == (out_taken ? 2'd2 : 2'd1)));

    // R7
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b10)
        |=> (out_taken && out_cycles == 2'd2 && out_next_pc == $past(rel_target)));

    // R8
    skip_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b11)
        |=> (out_cycles == (out_taken ? ($past(next_two_word) ? 2'd3 : 2'd2) : 2'd1)));

    // R9
    plain_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b00)
        |=> (!out_taken && out_cycles == 2'd1 && out_next_pc == $past(cur_pc) + PC_W'(1)));

endmodule

bind brskip_unit brskip_unit_chk #(.PC_W(PC_W), .OFS_W(OFS_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_kind      (req_kind),
    .use_named     (use_named),
    .flag_idx      (flag_idx),
    .flag_pol      (flag_pol),
    .status        (status),
    .rel_ofs       (rel_ofs),
    .cur_pc        (cur_pc),
    .next_two_word (next_two_word),
    .out_valid     (out_valid),
    .out_taken     (out_taken),
    .out_next_pc   (out_next_pc),
    .out_cycles    (out_cycles)
);

// File: tb/brskip_unit_bench.sv
`timescale 1ns/1ps
module brskip_unit_bench;

    localparam int PC_W  = 16;
    localparam int OFS_W = 7;
    localparam int PCMASK = (1 << PC_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [1:0]       req_kind = '0;
    logic             use_named = 1'b0;
    logic [3:0]       named_cond = '0;
    logic [2:0]       flag_idx = '0;
    logic             flag_pol = 1'b0;
    logic [7:0]       status = '0;
    logic [OFS_W-1:0] rel_ofs = '0;
    logic [PC_W-1:0]  cur_pc = '0;
    logic             skip_hit = 1'b0;
    logic             next_two_word = 1'b0;
    logic             out_valid;
    logic             out_taken;
    logic [PC_W-1:0]  out_next_pc;
    logic [1:0]       out_cycles;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // reference expectations
    int exp_valid = 0, exp_taken = 0, exp_pc = 0, exp_cyc = 0;

    always #4 clk = ~clk;

    brskip_unit #(.PC_W(PC_W), .OFS_W(OFS_W)) u_brskip_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .use_named(use_named), .named_cond(named_cond), .flag_idx(flag_idx),
        .flag_pol(flag_pol), .status(status), .rel_ofs(rel_ofs), .cur_pc(cur_pc),
        .skip_hit(skip_hit), .next_two_word(next_two_word), .out_valid(out_valid),
        .out_taken(out_taken), .out_next_pc(out_next_pc), .out_cycles(out_cycles)
    );

    function automatic int flag_of(int st, int idx);
        if (idx == 4) return ((st >> 2) & 1) ^ ((st >> 3) & 1);
        return (st >> idx) & 1;
    endfunction

    // named code -> index*2 + polarity
    function automatic int named_pair(int code);
        int tbl[16] = '{3, 2, 1, 0, 5, 4, 8, 9, 11, 10, 13, 12, 7, 6, 15, 14};
        return tbl[code];
    endfunction

    task automatic compare(string tag);
        compared++;
        if (out_valid !== exp_valid[0] || out_taken !== exp_taken[0] ||
            out_next_pc !== exp_pc[PC_W-1:0] || out_cycles !== exp_cyc[1:0]) begin
            mismatched++;
            $display("FAIL %s: got v=%0d t=%0d pc=%h cyc=%0d, expected v=%0d t=%0d pc=%h cyc=%0d",
                     tag, out_valid, out_taken, out_next_pc, out_cycles,
                     exp_valid, exp_taken, exp_pc, exp_cyc);
        end
    endtask

    task automatic drive(int kind, bit nm, int code, int idx, bit pol, int st,
                         int ofs, int pc, bit sh, bit tw, string tag);
        int hit, ix, pl;
        req_valid = 1'b1; req_kind = kind[1:0]; use_named = nm;
        named_cond = code[3:0]; flag_idx = idx[2:0]; flag_pol = pol;
        status = st[7:0]; rel_ofs = ofs[OFS_W-1:0]; cur_pc = pc[PC_W-1:0];
        skip_hit = sh; next_two_word = tw;
        ix = nm ? named_pair(code) / 2 : idx;
        pl = nm ? named_pair(code) % 2 : int'(pol);
        hit = (flag_of(st, ix) == pl);
        exp_valid = 1;
        case (kind)
            1: begin
                exp_taken = hit;
                exp_pc = hit ? (pc + ofs + 1) & PCMASK : (pc + 1) & PCMASK;
                exp_cyc = hit ? 2 : 1;
            end
            2: begin exp_taken = 1; exp_pc = (pc + ofs + 1) & PCMASK; exp_cyc = 2; end
            3: begin
                exp_taken = sh;
                exp_pc = sh ? (pc + (tw ? 3 : 2)) & PCMASK : (pc + 1) & PCMASK;
                exp_cyc = sh ? (tw ? 3 : 2) : 1;
            end
            default: begin exp_taken = 0; exp_pc = (pc + 1) & PCMASK; exp_cyc = 1; end
        endcase
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(int scramble);
        req_valid = 1'b0;
        req_kind = scramble[1:0]; cur_pc = scramble[15:0]; status = scramble[7:0];
        exp_valid = 0;
        @(negedge clk);
        compare("R2 hold");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        // R3 every raw index, both polarities, a pattern and its complement
        for (int i = 0; i < 8; i++)
            for (int p = 0; p < 2; p++) begin
                drive(1, 0, 0, i, p[0], 8'hA5, 10, 16'h0100, 0, 0, "R3 raw");
                drive(1, 0, 0, i, p[0], 8'h5A, -10, 16'h0100, 0, 0, "R3 raw");
            end
        // R4 stored S disagrees with N^V
        drive(1, 0, 0, 4, 1, 8'h10, 5, 16'h0200, 0, 0, "R4 signed");
        drive(1, 0, 0, 4, 0, 8'h10, 5, 16'h0200, 0, 0, "R4 signed");
        drive(1, 0, 0, 4, 1, 8'h04, 5, 16'h0200, 0, 0, "R4 signed");
        drive(1, 0, 0, 4, 1, 8'h0C, 5, 16'h0200, 0, 0, "R4 signed");
        // R5 every named code against complementary patterns
        for (int c = 0; c < 16; c++) begin
            drive(1, 1, c, 0, 0, 8'h00, 3, 16'h0300, 0, 0, "R5 named");
            drive(1, 1, c, 0, 0, 8'hFF, 3, 16'h0300, 0, 0, "R5 named");
            drive(1, 1, c, 0, 0, 8'h29, -3, 16'h0300, 0, 0, "R5 named");
        end
        // R6 offset extremes
        drive(1, 0, 0, 1, 1, 8'h02, 63, 16'h1000, 0, 0, "R6 branch");
        drive(1, 0, 0, 1, 1, 8'h02, -64, 16'h1000, 0, 0, "R6 branch");
        drive(1, 0, 0, 1, 1, 8'h00, -64, 16'h1000, 0, 0, "R6 branch");
        // R7 jump ignores conditions
        drive(2, 0, 0, 1, 1, 8'h00, -1, 16'h2000, 0, 1, "R7 jump");
        drive(2, 1, 0, 0, 0, 8'h00, 40, 16'h2000, 1, 0, "R7 jump");
        // R8 all skip combinations
        for (int s = 0; s < 4; s++)
            drive(3, 0, 0, 0, 0, 8'h00, 7, 16'h3000, s[1], s[0], "R8 skip");
        // R9 plain
        drive(0, 0, 0, 0, 0, 8'hFF, 20, 16'h4000, 1, 1, "R9 plain");
        // R10 wrap
        drive(1, 0, 0, 0, 1, 8'h01, 1, 16'hFFFF, 0, 0, "R10 wrap");
        drive(2, 0, 0, 0, 0, 8'h00, -5, 16'h0000, 0, 0, "R10 wrap");
        drive(3, 0, 0, 0, 0, 8'h00, 0, 16'hFFFE, 1, 1, "R10 wrap");
        drive(0, 0, 0, 0, 0, 8'h00, 0, 16'hFFFF, 0, 0, "R10 wrap");
        // R2 hold after a request
        idle(16'h5555);
        idle(16'hAAAA);
        // random stream, model compared every clock
        for (int n = 0; n < 600; n++) begin
            int k = $urandom_range(0, 3);
            if ($urandom_range(0, 5) == 0) idle(int'($urandom));
            else drive(k, 1'($urandom), $urandom_range(0, 15), $urandom_range(0, 7),
                       1'($urandom), $urandom_range(0, 255), $urandom_range(0, 127) - 64,
                       $urandom_range(0, PCMASK), 1'($urandom), 1'($urandom),
                       k == 0 ? "R9 rand" : k == 1 ? "R3 rand" : k == 2 ? "R7 rand" : "R8 rand");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule